// File: doc/BRIEF.md
# Dual-Controller Graphic LCD Writer

This block drives a 128x64 monochrome graphic panel whose columns are split across two 64-column controller chips, each with its own active-high chip select. A host issues one request at a time over a valid/ready handshake. The request is one of three kinds: a display data byte, a cursor move to a page and column, or a raw command byte aimed at the left chip, the right chip or both. The block turns each request into a short list of bus transfers and plays them out on the panel bus one after another, each with a timed enable strobe.

The block keeps one 128-column cursor for the whole panel. A data write goes to the chip that owns the cursor column. When the cursor reaches column 64, the block addresses the right chip before it writes there. When a write at column 127 completes, it moves on to the next page, wrapping from 7 to 0, and re-addresses the left chip. After reset the block pulses the panel reset, then programs the cursor home, the start line and display-on before it accepts any request. The panel busy flag is never read back. A fixed wait follows every transfer instead.

Top module: `glcd_writer`

## Requirements
- R1: While reset is in progress, `lcd_rst_n` is low, `lcd_en` is low and `req_ready` is low. Counting the clock in which `rst_n` is released, `lcd_rst_n` stays low for exactly RST_CYC clocks.
- R2: After `lcd_rst_n` rises and RST_WAIT_CYC clocks pass, the block sends four commands with `lcd_di`=0. The first two go to the left chip only ({cs2,cs1}=01): 8'hB8 and 8'h40. The last two go to both chips ({cs2,cs1}=11): 8'hC0 and 8'h3F. Only then does `req_ready` rise.
- R3: A cursor move (`req_kind`=2'b01) clamps `req_line` to at most 7 and `req_col` to at most 127. It sends 8'hB8+page and then 8'h40+(column mod 64), both with `lcd_di`=0. They go to the left chip when column bit 6 is 0 and to the right chip when it is 1.
- R4: A data write (`req_kind`=2'b00) puts `req_data` on the bus with `lcd_di`=1. It selects exactly one chip: the left chip for cursor columns 0 to 63 and the right chip for columns 64 to 127. The cursor column then advances by one.
- R5: A data write at cursor column 64 is preceded by two commands to the right chip: 8'hB8+page and then 8'h40.
- R6: A data write at cursor column 127 goes to the right chip. The page then advances modulo 8 and the column becomes 0. Two commands then go to the left chip: 8'hB8+new page and 8'h40.
- R7: A command request (`req_kind`=2'b10 or 2'b11) sends `req_data` once with `lcd_di`=0. `lcd_cs1` is set to `req_target` bit 0 and `lcd_cs2` to `req_target` bit 1. The cursor is left unchanged.
- R8: `lcd_rw` is 0 (write) for every transfer.
- R9: For each transfer, the select, data/instruction and data lines are set at least SETUP_CYC clocks before `lcd_en` rises. `lcd_en` stays high for exactly HIGH_CYC clocks. The lines do not change for at least HOLD_CYC clocks after `lcd_en` falls.
- R10: `req_ready` falls in the clock after a request is accepted. It stays low while transfers are in progress. It rises exactly HOLD_CYC+WAIT_CYC+1 clocks after the last `lcd_en` fall of that request. `lcd_en` is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 00 data, 01 cursor move, 10/11 command |
| req_target | input | 2 | Command chip mask: bit 0 left, bit 1 right |
| req_data | input | 8 | Data byte or command byte |
| req_line | input | 8 | Page for a cursor move (clamped to 7) |
| req_col | input | 8 | Column for a cursor move (clamped to 127) |
| lcd_cs1 | output | 1 | Left chip select, active high |
| lcd_cs2 | output | 1 | Right chip select, active high |
| lcd_di | output | 1 | 1 = display data, 0 = command |
| lcd_rw | output | 1 | Read/write line, always write (0) |
| lcd_en | output | 1 | Enable strobe; byte latched on its fall |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_db | output | 8 | Panel data bus |

## Verification
Each transfer is checked in the first clock in which `lcd_en` is seen low after being high. At that point the select, data/instruction and data lines are still in their hold window, so the bench compares them there against the next entry of a queue that it filled from its own cursor model when it issued the request. Strobe widths and setup margins are counted clock by clock from the sampled `lcd_en` and bus lines. `req_ready` is checked low one clock after acceptance, and its return is checked at exactly HOLD_CYC+WAIT_CYC+1 clocks after the last observed enable fall. The panel reset output is counted low for exactly RST_CYC clocks, starting with the clock in which reset is released.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    localparam int PAGE_W  = 3;
    localparam int COL_W   = 7;
    localparam int MAX_OPS = 4;
    localparam int IDX_W   = $clog2(MAX_OPS);
    localparam int OPS_W   = $clog2(MAX_OPS + 1);

    localparam logic [7:0] OP_PAGE   = 8'hB8;
    localparam logic [7:0] OP_COLUMN = 8'h40;
    localparam logic [7:0] OP_START  = 8'hC0;
    localparam logic [7:0] OP_ON     = 8'h3F;

    localparam logic [1:0] SEL_LEFT  = 2'b01;
    localparam logic [1:0] SEL_RIGHT = 2'b10;
    localparam logic [1:0] SEL_BOTH  = 2'b11;

    typedef struct packed {
        logic [1:0] cs;
        logic       di;
        logic [7:0] val;
    } xfer_t;

    function automatic xfer_t mk_xfer(input logic [1:0] cs, input logic di, input logic [7:0] val);
        xfer_t x;
        x.cs  = cs;
        x.di  = di;
        x.val = val;
        return x;
    endfunction

endpackage

// File: rtl/glcd_plan.sv
module glcd_plan
    import glcd_pkg::*;
(
    input  logic [1:0]                     kind_i,
    input  logic [1:0]                     target_i,
    input  logic [7:0]                     data_i,
    input  logic [7:0]                     line_i,
    input  logic [7:0]                     col_i,
    input  logic [PAGE_W-1:0]              cur_page_i,
    input  logic [COL_W-1:0]               cur_col_i,
    output xfer_t [MAX_OPS-1:0]            ops_o,
    output logic [OPS_W-1:0]               nops_o,
    output logic [PAGE_W-1:0]              nxt_page_o,
    output logic [COL_W-1:0]               nxt_col_o
);

    logic [PAGE_W-1:0] clamp_page;
    logic [COL_W-1:0]  clamp_col;
    logic [1:0]        goto_sel;
    logic [1:0]        data_sel;
    logic [PAGE_W-1:0] wrap_page;

    always_comb begin
        clamp_page = (line_i > 8'd7)   ? 3'd7   : line_i[PAGE_W-1:0];
        clamp_col  = (col_i  > 8'd127) ? 7'd127 : col_i[COL_W-1:0];
        goto_sel   = clamp_col[COL_W-1] ? SEL_RIGHT : SEL_LEFT;
        data_sel   = cur_col_i[COL_W-1] ? SEL_RIGHT : SEL_LEFT;
        wrap_page  = cur_page_i + 3'd1;

        ops_o      = '0;
        nops_o     = '0;
        nxt_page_o = cur_page_i;
        nxt_col_o  = cur_col_i;

        case (kind_i)
            2'b01: begin
                ops_o[0]   = mk_xfer(goto_sel, 1'b0, OP_PAGE + 8'(clamp_page));
                ops_o[1]   = mk_xfer(goto_sel, 1'b0, OP_COLUMN + {2'b00, clamp_col[COL_W-2:0]});
                nops_o     = OPS_W'(2);
                nxt_page_o = clamp_page;
                nxt_col_o  = clamp_col;
            end
            2'b00: begin
                if (cur_col_i == 7'd64) begin
                    ops_o[0]  = mk_xfer(SEL_RIGHT, 1'b0, OP_PAGE + 8'(cur_page_i));
                    ops_o[1]  = mk_xfer(SEL_RIGHT, 1'b0, OP_COLUMN);
                    ops_o[2]  = mk_xfer(SEL_RIGHT, 1'b1, data_i);
                    nops_o    = OPS_W'(3);
                    nxt_col_o = cur_col_i + 7'd1;
                end else if (cur_col_i == 7'd127) begin
                    ops_o[0]   = mk_xfer(SEL_RIGHT, 1'b1, data_i);
                    ops_o[1]   = mk_xfer(SEL_LEFT, 1'b0, OP_PAGE + 8'(wrap_page));
                    ops_o[2]   = mk_xfer(SEL_LEFT, 1'b0, OP_COLUMN);
                    nops_o     = OPS_W'(3);
                    nxt_page_o = wrap_page;
                    nxt_col_o  = '0;
                end else begin
                    ops_o[0]  = mk_xfer(data_sel, 1'b1, data_i);
                    nops_o    = OPS_W'(1);
                    nxt_col_o = cur_col_i + 7'd1;
                end
            end
            default: begin
                ops_o[0] = mk_xfer(target_i, 1'b0, data_i);
                nops_o   = OPS_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/glcd_strobe.sv
module glcd_strobe
    import glcd_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 3,
    parameter int HOLD_CYC  = 1,
    parameter int WAIT_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  xfer_t      xfer_i,
    output logic       idle_o,
    output logic       en_o,
    output xfer_t      bus_o
);

    localparam int SETUP_N = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
    localparam int HIGH_N  = (HIGH_CYC  < 1) ? 1 : HIGH_CYC;
    localparam int HOLD_N  = (HOLD_CYC  < 1) ? 1 : HOLD_CYC;
    localparam int WAIT_N  = (WAIT_CYC  < 1) ? 1 : WAIT_CYC;
    localparam int MAX_A   = (SETUP_N > HIGH_N) ? SETUP_N : HIGH_N;
    localparam int MAX_B   = (HOLD_N > WAIT_N) ? HOLD_N : WAIT_N;
    localparam int MAX_N   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_N + 1);

    typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_WAIT} phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        xfer_t            bus;
        logic             en;
    } strobe_t;

    strobe_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                s_d.ph  = PH_SETUP;
                s_d.cnt = CNT_W'(SETUP_N - 1);
                s_d.bus = xfer_i;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end else begin
            case (s_q.ph)
                PH_SETUP: begin s_d.ph = PH_HIGH; s_d.cnt = CNT_W'(HIGH_N - 1); end
                PH_HIGH:  begin s_d.ph = PH_HOLD; s_d.cnt = CNT_W'(HOLD_N - 1); end
                PH_HOLD:  begin s_d.ph = PH_WAIT; s_d.cnt = CNT_W'(WAIT_N - 1); end
                default:  begin s_d.ph = PH_IDLE; s_d.cnt = '0; end
            endcase
        end
        s_d.en = (s_d.ph == PH_HIGH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, bus: '0, en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_o = (s_q.ph == PH_IDLE);
    assign en_o   = s_q.en;
    assign bus_o  = s_q.bus;

    logic [CNT_W-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_run_q <= '0;
        else if (s_q.en)  hi_run_q <= hi_run_q + CNT_W'(1);
        else              hi_run_q <= '0;
    end

    AST_BUS_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en |-> $stable(s_q.bus)); // R9
    AST_EN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.en) |-> (hi_run_q == CNT_W'(HIGH_N))); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle_o) |=> !idle_o && !en_o); // R9

endmodule

// File: rtl/glcd_writer.sv
module glcd_writer
    import glcd_pkg::*;
#(
    parameter int SETUP_CYC    = 2,
    parameter int HIGH_CYC     = 3,
    parameter int HOLD_CYC     = 1,
    parameter int WAIT_CYC     = 4,
    parameter int RST_CYC      = 5,
    parameter int RST_WAIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_kind,
    input  logic [1:0] req_target,
    input  logic [7:0] req_data,
    input  logic [7:0] req_line,
    input  logic [7:0] req_col,
    output logic       lcd_cs1,
    output logic       lcd_cs2,
    output logic       lcd_di,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic       lcd_rst_n,
    output logic [7:0] lcd_db
);

    localparam int RST_N  = (RST_CYC < 1) ? 1 : RST_CYC;
    localparam int RWT_N  = (RST_WAIT_CYC < 1) ? 1 : RST_WAIT_CYC;
    localparam int RMAX   = (RST_N > RWT_N) ? RST_N : RWT_N;
    localparam int RCNT_W = $clog2(RMAX + 1);

    typedef enum logic [1:0] {T_RST, T_REL, T_RUN, T_IDLE} top_e;

    typedef struct packed {
        top_e                  st;
        logic [RCNT_W-1:0]     cnt;
        xfer_t [MAX_OPS-1:0]   ops;
        logic [OPS_W-1:0]      nops;
        logic [OPS_W-1:0]      idx;
        logic                  started;
        logic [PAGE_W-1:0]     page;
        logic [COL_W-1:0]      col;
        logic                  rstn;
    } wr_t;

    wr_t q, d;

    xfer_t [MAX_OPS-1:0] plan_ops;
    xfer_t [MAX_OPS-1:0] init_ops;
    logic [OPS_W-1:0]    plan_nops;
    logic [PAGE_W-1:0]   plan_page;
    logic [COL_W-1:0]    plan_col;
    logic                stb_idle;
    logic                stb_start;
    logic                stb_en;
    xfer_t               stb_bus;

    glcd_plan u_plan (
        .kind_i     (req_kind),
        .target_i   (req_target),
        .data_i     (req_data),
        .line_i     (req_line),
        .col_i      (req_col),
        .cur_page_i (q.page),
        .cur_col_i  (q.col),
        .ops_o      (plan_ops),
        .nops_o     (plan_nops),
        .nxt_page_o (plan_page),
        .nxt_col_o  (plan_col)
    );

    glcd_strobe #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAIT_CYC  (WAIT_CYC)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (stb_start),
        .xfer_i  (q.ops[q.idx[IDX_W-1:0]]),
        .idle_o  (stb_idle),
        .en_o    (stb_en),
        .bus_o   (stb_bus)
    );

    always_comb begin
        init_ops[0] = mk_xfer(SEL_LEFT, 1'b0, OP_PAGE);
        init_ops[1] = mk_xfer(SEL_LEFT, 1'b0, OP_COLUMN);
        init_ops[2] = mk_xfer(SEL_BOTH, 1'b0, OP_START);
        init_ops[3] = mk_xfer(SEL_BOTH, 1'b0, OP_ON);
    end

    always_comb begin
        d         = q;
        stb_start = 1'b0;
        case (q.st)
            T_RST: begin
                if (q.cnt == '0) begin
                    d.st  = T_REL;
                    d.cnt = RCNT_W'(RWT_N - 1);
                end else begin
                    d.cnt = q.cnt - RCNT_W'(1);
                end
            end
            T_REL: begin
                if (q.cnt == '0) begin
                    d.st      = T_RUN;
                    d.ops     = init_ops;
                    d.nops    = OPS_W'(MAX_OPS);
                    d.idx     = '0;
                    d.started = 1'b0;
                    d.page    = '0;
                    d.col     = '0;
                end else begin
                    d.cnt = q.cnt - RCNT_W'(1);
                end
            end
            T_IDLE: begin
                if (req_valid) begin
                    d.st      = T_RUN;
                    d.ops     = plan_ops;
                    d.nops    = plan_nops;
                    d.idx     = '0;
                    d.started = 1'b0;
                    d.page    = plan_page;
                    d.col     = plan_col;
                end
            end
            default: begin
                if (!q.started) begin
                    if (stb_idle) begin
                        stb_start = 1'b1;
                        d.started = 1'b1;
                    end
                end else if (stb_idle) begin
                    d.started = 1'b0;
                    if (q.idx == q.nops - OPS_W'(1)) begin
                        d.st = T_IDLE;
                    end else begin
                        d.idx = q.idx + OPS_W'(1);
                    end
                end
            end
        endcase
        d.rstn = (d.st != T_RST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= T_RST;
            q.cnt  <= RCNT_W'(RST_N - 1);
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == T_IDLE);
    assign lcd_cs1   = stb_bus.cs[0];
    assign lcd_cs2   = stb_bus.cs[1];
    assign lcd_di    = stb_bus.di;
    assign lcd_db    = stb_bus.val;
    assign lcd_en    = stb_en;
    assign lcd_rw    = 1'b0;
    assign lcd_rst_n = q.rstn;

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (!req_ready && !lcd_en)); // R1
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10
    AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_en); // R10
    AST_DATA_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && lcd_di) |-> ($countones({lcd_cs2, lcd_cs1}) == 1)); // R4
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b00 && q.col != 7'd127)
        |=> (q.col == $past(q.col) + 7'd1) && $stable(q.page)); // R4
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b00 && q.col == 7'd127)
        |=> (q.col == 7'd0) && (q.page == $past(q.page) + 3'd1)); // R6
    AST_CMD_KEEPS_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind[1]) |=> $stable(q.col) && $stable(q.page)); // R7

endmodule

// File: tb/tb_glcd_writer.sv
module tb_glcd_writer;

    localparam int SETUP = 2;
    localparam int HIGH  = 3;
    localparam int HOLD  = 1;
    localparam int WAITC = 4;
    localparam int RSTC  = 5;
    localparam int RWAIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = '0;
    logic [1:0] req_target = '0;
    logic [7:0] req_data = '0;
    logic [7:0] req_line = '0;
    logic [7:0] req_col = '0;
    logic       lcd_cs1, lcd_cs2, lcd_di, lcd_rw, lcd_en, lcd_rst_n;
    logic [7:0] lcd_db;

    always #5 clk = ~clk;

    glcd_writer #(
        .SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .HOLD_CYC(HOLD),
        .WAIT_CYC(WAITC), .RST_CYC(RSTC), .RST_WAIT_CYC(RWAIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_target(req_target), .req_data(req_data),
        .req_line(req_line), .req_col(req_col),
        .lcd_cs1(lcd_cs1), .lcd_cs2(lcd_cs2), .lcd_di(lcd_di), .lcd_rw(lcd_rw),
        .lcd_en(lcd_en), .lcd_rst_n(lcd_rst_n), .lcd_db(lcd_db)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int ncyc    = 0;
    int last_fall = 0;

    logic [10:0] expq[$];
    string       tagq[$];

    int cur_page = 0;
    int cur_col  = 0;

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    task automatic push(input bit [1:0] cs, input bit di, input bit [7:0] v, input string tag);
        expq.push_back({cs, di, v});
        tagq.push_back(tag);
    endtask

    // Bus monitor: every transfer is compared when enable is seen falling
    logic [10:0] prev_bus = '0;
    logic        prev_en  = 1'b0;
    int          stab = 0;
    int          hi   = 0;
    int          since_fall = 100;

    always @(negedge clk) begin
        logic [10:0] bus;
        logic [10:0] e;
        string       t;
        bus = {lcd_cs2, lcd_cs1, lcd_di, lcd_db};
        if (rst_n) begin
            if (bus != prev_bus) begin
                chk(since_fall > HOLD, "R9 hold", since_fall, HOLD + 1);
                stab = 1;
            end else begin
                stab++;
            end
            if (lcd_en && !prev_en) chk(stab >= SETUP + 1, "R9 setup", stab - 1, SETUP);
            if (lcd_en) hi++;
            if (!lcd_en && prev_en) begin
                chk(hi == HIGH, "R9 width", hi, HIGH);
                chk(lcd_rw == 1'b0, "R8", lcd_rw, 0);
                hi = 0;
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected transfer", bus, 0);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(bus == e, t, bus, e);
                end
                last_fall  = ncyc;
                since_fall = 0;
            end else begin
                since_fall++;
            end
        end
        prev_bus = bus;
        prev_en  = lcd_en;
    end

    task automatic do_req(input bit [1:0] k, input bit [1:0] t, input bit [7:0] dv,
                          input bit [7:0] ln, input bit [7:0] cl);
        int    p;
        int    c;
        bit [1:0] sel;
        string tg;
        if (k == 2'b01) begin
            p = (ln > 7) ? 7 : int'(ln);
            c = (cl > 127) ? 127 : int'(cl);
            sel = (c >= 64) ? 2'b10 : 2'b01;
            tg = "R3";
            push(sel, 1'b0, 8'hB8 + 8'(p), "R3");
            push(sel, 1'b0, 8'h40 + 8'(c % 64), "R3");
            cur_page = p;
            cur_col  = c;
        end else if (k == 2'b00) begin
            if (cur_col == 64) begin
                tg = "R5";
                push(2'b10, 1'b0, 8'hB8 + 8'(cur_page), "R5");
                push(2'b10, 1'b0, 8'h40, "R5");
                push(2'b10, 1'b1, dv, "R5");
                cur_col++;
            end else if (cur_col == 127) begin
                tg = "R6";
                push(2'b10, 1'b1, dv, "R6");
                cur_page = (cur_page + 1) % 8;
                cur_col  = 0;
                push(2'b01, 1'b0, 8'hB8 + 8'(cur_page), "R6");
                push(2'b01, 1'b0, 8'h40, "R6");
            end else begin
                tg = "R4";
                push((cur_col >= 64) ? 2'b10 : 2'b01, 1'b1, dv, "R4");
                cur_col++;
            end
        end else begin
            tg = "R7";
            push(t, 1'b0, dv, "R7");
        end
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = k;
        req_target = t;
        req_data   = dv;
        req_line   = ln;
        req_col    = cl;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready drop", req_ready, 0);
        while (!req_ready) @(negedge clk);
        chk(ncyc - last_fall == HOLD + WAITC + 1, "R10 ready return", ncyc - last_fall, HOLD + WAITC + 1);
        chk(expq.size() == 0, tg, expq.size(), 0);
    endtask

    initial begin
        #(10 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int rc;
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        chk(lcd_rst_n == 1'b0, "R1 rst out", lcd_rst_n, 0);
        chk(req_ready == 1'b0, "R1 ready", req_ready, 0);
        chk(lcd_en == 1'b0, "R1 enable", lcd_en, 0);

        push(2'b01, 1'b0, 8'hB8, "R2");
        push(2'b01, 1'b0, 8'h40, "R2");
        push(2'b11, 1'b0, 8'hC0, "R2");
        push(2'b11, 1'b0, 8'h3F, "R2");
        rst_n = 1'b1;
        rc = 0;
        while (lcd_rst_n == 1'b0) begin
            chk(req_ready == 1'b0 && lcd_en == 1'b0, "R1 quiet", {req_ready, lcd_en}, 0);
            rc++;
            @(negedge clk);
        end
        chk(rc == RSTC, "R1 length", rc, RSTC);
        while (!req_ready) @(negedge clk);
        chk(expq.size() == 0, "R2 init done", expq.size(), 0);

        // Directed corner cases
        do_req(2'b01, 2'b00, 8'h00, 8'd9, 8'd200);   // R3 clamp to page 7 column 127
        do_req(2'b00, 2'b00, 8'hA5, 8'd0, 8'd0);     // R6 wrap page 7 -> 0
        do_req(2'b00, 2'b00, 8'h11, 8'd0, 8'd0);     // R4 column 0 on left chip
        do_req(2'b01, 2'b00, 8'h00, 8'd3, 8'd62);    // R3
        do_req(2'b00, 2'b00, 8'h21, 8'd0, 8'd0);     // R4 column 62
        do_req(2'b00, 2'b00, 8'h22, 8'd0, 8'd0);     // R4 column 63
        do_req(2'b00, 2'b00, 8'h23, 8'd0, 8'd0);     // R5 column 64 crossing
        do_req(2'b00, 2'b00, 8'h24, 8'd0, 8'd0);     // R4 column 65 right chip
        do_req(2'b10, 2'b11, 8'h3F, 8'd0, 8'd0);     // R7 both chips
        do_req(2'b10, 2'b01, 8'hC5, 8'd0, 8'd0);     // R7 left only
        do_req(2'b11, 2'b10, 8'h3E, 8'd0, 8'd0);     // R7 right only, alternate code
        do_req(2'b00, 2'b00, 8'h25, 8'd0, 8'd0);     // R7 cursor kept at 66
        do_req(2'b01, 2'b00, 8'h00, 8'd0, 8'd64);    // R3 right chip column 0
        do_req(2'b00, 2'b00, 8'h26, 8'd0, 8'd0);     // R5 again at 64

        // Constrained random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            bit [1:0] k;
            r = $urandom % 100;
            if (r < 60)      k = 2'b00;
            else if (r < 85) k = 2'b01;
            else             k = 2'b10 | 2'($urandom % 2);
            do_req(k, 2'($urandom % 4), 8'($urandom),
                   8'($urandom % 12), 8'((($urandom % 4) == 0) ? ($urandom % 256) : ($urandom % 128)));
        end

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R4 queue drained", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule